// File: doc/BRIEF.md
# Grouped Vector Unsigned-Integer to Single-Precision Converter

This block carries out one grouped conversion instruction at a time. It takes a 32-bit instruction word and recognises two forms. One form covers an aligned pair of vector registers and the other covers an aligned quad. Each form names a source group and a destination group. The block then reads the source registers one after another through a register-file read port. Every 32-bit lane is treated as an unsigned integer and converted to an IEEE-754 single-precision value. The rounding mode comes from a 2-bit control input.

All converted registers are held in an internal buffer. Writing to the destination group starts only after the last source read. A destination group that is the same as its source group therefore converts in place with the correct result. A one-cycle completion pulse follows the final write. A word that matches neither form raises a one-cycle undefined-instruction pulse and changes no register. The vector length is a parameter and must be a multiple of 32.

Top module: `vec_u2f_group`

## Requirements
- R1: The pair form has bits [31:10] equal to 1100000100100010111000, bit 5 set and bit 0 clear. Its source group starts at register {instr[9:6],0} and its destination group starts at register {instr[4:1],0}. It covers two consecutive registers. No other register is written.
- R2: The quad form has bits [31:10] equal to 1100000100110010111000, bit 6 clear, bit 5 set and bits [1:0] clear. Its source group starts at register {instr[9:7],00} and its destination group starts at register {instr[4:2],00}. It covers four consecutive registers. No other register is written.
- R3: A word accepted while `start` is high that matches neither form produces `undef` high for exactly the following cycle. No read and no write take place, and every register keeps its value.
- R4: A lane value of zero gives 0x00000000. A value below 2^24 converts exactly: the exponent field is 127 + the index of its top set bit, and the trailing bits are left-aligned into the 23-bit fraction.
- R5: With `rmode` = 00 (nearest, ties to even), a wider value rounds to the nearer representable single. An exact tie goes to the even significand.
- R6: With `rmode` = 01 (toward +inf), any nonzero discarded bits round the magnitude up. With 10 (toward -inf) and 11 (toward zero), the discarded bits are truncated.
- R7: A round-up that overflows the 24-bit significand gives a fraction of zero and an exponent one higher.
- R8: Every lane of every register in the group is converted. Lane i of destination register k comes from lane i of source register k.
- R9: All source reads of an instruction finish before its first write. An in-place group (destination equal to source) gives the same results as a disjoint group.
- R10: Reads take one cycle each, at ascending addresses from the source base, followed without a gap by one write per cycle at ascending addresses from the destination base. `done` is high for exactly the one cycle after the last write.
- R11: During and right after reset, `rd_en`, `wr_en`, `done` and `undef` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid; accepted only when idle |
| instr | input | 32 | Instruction word |
| rmode | input | 2 | Rounding mode, captured with the instruction |
| rd_en | output | 1 | Register read strobe |
| rd_addr | output | 5 | Register read address |
| rd_data | input | VLEN | Read data for rd_addr, same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register write address |
| wr_data | output | VLEN | Converted register contents |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle undefined-instruction pulse |

## Verification
Two things happen in the same conversion cycle: capture of a source register into the result buffer, and rounding of every lane of that register. A lane that rounds up and carries into the exponent can sit next to a lane that converts exactly. The bench provokes this by filling every register with lanes that mix exact values, ties, carry-out cases and hashed wide values. It covers all four rounding modes, both forms, and in-place as well as disjoint groups. Each lane is judged against a reference built from the quotient and remainder of an integer shift. A port monitor separately checks that the read phase and the write phase never overlap.

// File: rtl/vec_u2f_group.sv
module vec_u2f_group #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [1:0]      rmode,
  output logic            rd_en,
  output logic [4:0]      rd_addr,
  input  logic [VLEN-1:0] rd_data,
  output logic            wr_en,
  output logic [4:0]      wr_addr,
  output logic [VLEN-1:0] wr_data,
  output logic            done,
  output logic            undef
);
  localparam int LANES = VLEN / 32;
  localparam logic [21:0] OP_PAIR = 22'b1100000100100010111000;
  localparam logic [21:0] OP_QUAD = 22'b1100000100110010111000;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} state_t;

  state_t          st;
  logic [1:0]      cnt, last;
  logic [4:0]      src_b, dst_b;
  logic [1:0]      rm_q;
  logic            undef_q;
  logic [VLEN-1:0] res_q [4];
  logic [VLEN-1:0] conv;

  wire is_pair = instr[31:10] == OP_PAIR && instr[5] && !instr[0];
  wire is_quad = instr[31:10] == OP_QUAD && !instr[6] && instr[5] && instr[1:0] == 2'b00;

  function automatic logic [31:0] u2f(input logic [31:0] x, input logic [1:0] rm);
    logic [4:0]  p;
    logic [31:0] n;
    logic        g, s, up;
    p = 5'd0;
    for (int i = 0; i < 32; i++)
      if (x[i]) p = i[4:0];
    n = x << (5'd31 - p);
    g = n[7];
    s = |n[6:0];
    case (rm)
      2'b00:   up = g & (s | n[8]);
      2'b01:   up = g | s;
      default: up = 1'b0;
    endcase
    if (x == 32'd0) return 32'd0;
    return {1'b0, 8'd127 + {3'b000, p}, n[30:8]} + {31'd0, up};
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign conv[l*32 +: 32] = u2f(rd_data[l*32 +: 32], rm_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= 2'd0;
      last    <= 2'd0;
      src_b   <= 5'd0;
      dst_b   <= 5'd0;
      rm_q    <= 2'd0;
      undef_q <= 1'b0;
    end else begin
      undef_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cnt  <= 2'd0;
          rm_q <= rmode;
          if (is_pair) begin
            src_b <= {instr[9:6], 1'b0};
            dst_b <= {instr[4:1], 1'b0};
            last  <= 2'd1;
            st    <= S_READ;
          end else if (is_quad) begin
            src_b <= {instr[9:7], 2'b00};
            dst_b <= {instr[4:2], 2'b00};
            last  <= 2'd3;
            st    <= S_READ;
          end else begin
            undef_q <= 1'b1;
          end
        end
        S_READ: begin
          cnt <= (cnt == last) ? 2'd0 : cnt + 2'd1;
          if (cnt == last) st <= S_WRITE;
        end
        S_WRITE: begin
          cnt <= (cnt == last) ? 2'd0 : cnt + 2'd1;
          if (cnt == last) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_READ) res_q[cnt] <= conv;

  assign rd_en   = st == S_READ;
  assign rd_addr = src_b + {3'b000, cnt};
  assign wr_en   = st == S_WRITE;
  assign wr_addr = dst_b + {3'b000, cnt};
  assign wr_data = res_q[cnt];
  assign done    = st == S_DONE;
  assign undef   = undef_q;

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rd_en, wr_en, done, undef})); // R3
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n) rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 5'd1); // R10
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n) wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 5'd1); // R10
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_en) |-> $past(rd_en)); // R9
  AST_NO_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !rd_en); // R9
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(wr_en) && !wr_en); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
endmodule

// File: tb/test_vec_u2f_group.sv
module test_vec_u2f_group;
  localparam int VLEN  = 64;
  localparam int LANES = VLEN / 32;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] instr = '0;
  logic [1:0]  rmode = '0;
  logic rd_en, wr_en, done, undef;
  logic [4:0] rd_addr, wr_addr;
  logic [VLEN-1:0] rd_data, wr_data;

  logic [VLEN-1:0] rf   [32];
  logic [VLEN-1:0] snap [32];
  logic            ld_en = 0;
  logic [4:0]      ld_addr = '0;
  logic [VLEN-1:0] ld_data = '0;

  int tests = 0, fails = 0, m_tests = 0, m_fails = 0;
  int e_src = 0, e_dst = 0, e_n = 0;

  always #2.5 clk = ~clk;

  vec_u2f_group #(.VLEN(VLEN)) i_vec_u2f_group (
    .clk, .rst_n, .start, .instr, .rmode, .rd_en, .rd_addr, .rd_data,
    .wr_en, .wr_addr, .wr_data, .done, .undef);

  assign rd_data = rf[rd_addr];
  always @(posedge clk)
    if (wr_en) rf[wr_addr] <= wr_data;
    else if (ld_en) rf[ld_addr] <= ld_data;

  int rd_c = 0, wr_c = 0;
  bit prev_wr = 0;
  always @(negedge clk) begin
    if (!rst_n) begin rd_c = 0; wr_c = 0; prev_wr = 0; end
    else begin
      if (rd_en) begin
        m_tests++;
        if (wr_c != 0 || rd_addr != 5'(e_src + rd_c)) begin
          m_fails++;
          $display("FAIL R9/R10 read addr act=%0d exp=%0d writes_seen=%0d", rd_addr, e_src + rd_c, wr_c);
        end
        rd_c++;
      end
      if (wr_en) begin
        m_tests++;
        if (rd_c != e_n || wr_addr != 5'(e_dst + wr_c)) begin
          m_fails++;
          $display("FAIL R9/R10 write addr act=%0d exp=%0d reads_seen=%0d", wr_addr, e_dst + wr_c, rd_c);
        end
        wr_c++;
      end
      if (done) begin
        m_tests++;
        if (!prev_wr || wr_c != e_n) begin
          m_fails++;
          $display("FAIL R10 done timing act_writes=%0d exp=%0d prev_wr=%0d", wr_c, e_n, prev_wr);
        end
        rd_c = 0; wr_c = 0;
      end
      if (undef) begin rd_c = 0; wr_c = 0; end
      prev_wr = wr_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm, output string tag);
    int p, e, sh;
    logic [63:0] q, rem, half;
    bit up;
    if (x == 0) begin tag = "R4 zero"; return 32'd0; end
    p = 31;
    while (!x[p]) p--;
    e = 127 + p;
    if (p <= 23) begin
      tag = "R4 exact";
      q = {32'd0, x} << (23 - p);
    end else begin
      sh   = p - 23;
      q    = {32'd0, x} >> sh;
      rem  = {32'd0, x} & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rm == 2'b00) up = (rem > half) || (rem == half && q[0]);
      else if (rm == 2'b01) up = rem != 0;
      else up = 0;
      tag = (rm == 2'b00) ? "R5 nearest-even" : "R6 directed";
      q = q + {63'd0, up};
      if (q == 64'd1 << 24) begin q = q >> 1; e++; tag = "R7 exponent carry"; end
    end
    return {1'b0, e[7:0], q[22:0]};
  endfunction

  function automatic logic [31:0] gen(input int g);
    logic [31:0] h;
    if (g % 4 == 0)
      case ((g / 4) % 16)
        0: return 32'h0;          1: return 32'h1;
        2: return 32'h00FFFFFF;   3: return 32'h01000000;
        4: return 32'h01000001;   5: return 32'h01000003;
        6: return 32'hFFFFFFFF;   7: return 32'h80000000;
        8: return 32'h80000080;   9: return 32'h80000180;
        10: return 32'hFFFFFF80;  11: return 32'h7FFFFFC0;
        12: return 32'h01000002;  13: return 32'h00000300;
        14: return 32'h0000FFFF;  default: return 32'hFFFFFF7F;
      endcase
    h = g * 32'h9E3779B9;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h >> h[31:29];
  endfunction

  task automatic load_all(input int seed);
    for (int r = 0; r < 32; r++) begin
      @(negedge clk);
      ld_en = 1; ld_addr = 5'(r);
      for (int l = 0; l < LANES; l++) ld_data[l*32 +: 32] = gen(seed + r * LANES + l);
    end
    @(negedge clk); ld_en = 0;
  endtask

  function automatic logic [31:0] mk_pair(input int s, input int d);
    return {22'b1100000100100010111000, 4'(s), 1'b1, 4'(d), 1'b0};
  endfunction
  function automatic logic [31:0] mk_quad(input int s, input int d);
    return {22'b1100000100110010111000, 3'(s), 1'b0, 1'b1, 3'(d), 2'b00};
  endfunction

  task automatic run_valid(input logic [31:0] w, input bit quad, input int sf, input int df, input logic [1:0] rm);
    int n, sb, db, waited;
    logic [31:0] exp;
    string tag, ftag;
    bit reg_ok;
    n  = quad ? 4 : 2;
    sb = quad ? sf * 4 : sf * 2;
    db = quad ? df * 4 : df * 2;
    ftag = quad ? "R2" : "R1";
    for (int r = 0; r < 32; r++) snap[r] = rf[r];
    e_src = sb; e_dst = db; e_n = n;
    @(negedge clk); instr = w; rmode = rm; start = 1;
    @(negedge clk); start = 0;
    waited = 0;
    while (!done && waited < 20) begin @(negedge clk); waited++; end
    chk(done, "R10 done seen", 64'(done), 64'd1);
    @(negedge clk);
    for (int r = 0; r < n; r++) begin
      reg_ok = 1;
      for (int l = 0; l < LANES; l++) begin
        exp = ref_cvt(snap[sb + r][l*32 +: 32], rm, tag);
        chk(rf[db + r][l*32 +: 32] == exp, tag, 64'(rf[db + r][l*32 +: 32]), 64'(exp));
        if (rf[db + r][l*32 +: 32] != exp) reg_ok = 0;
      end
      chk(reg_ok, (sb == db) ? "R8,R9 in-place register" : "R8 register", 64'(db + r), 64'(sb + r));
    end
    for (int r = 0; r < 32; r++)
      if (r < db || r >= db + n)
        chk(rf[r] == snap[r], ftag, 64'(rf[r]), 64'(snap[r]));
  endtask

  task automatic run_bad(input logic [31:0] w);
    bit any_wr;
    for (int r = 0; r < 32; r++) snap[r] = rf[r];
    @(negedge clk); instr = w; start = 1;
    @(negedge clk); start = 0;
    chk(undef, "R3 undef pulse", 64'(undef), 64'd1);
    any_wr = rd_en | wr_en;
    @(negedge clk);
    chk(!undef, "R3 undef one cycle", 64'(undef), 64'd0);
    for (int i = 0; i < 6; i++) begin any_wr |= rd_en | wr_en | done; @(negedge clk); end
    chk(!any_wr, "R3 no access", 64'(any_wr), 64'd0);
    for (int r = 0; r < 32; r++) chk(rf[r] == snap[r], "R3 registers kept", 64'(rf[r]), 64'(snap[r]));
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests + m_tests + 1, fails + m_fails + 1);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) rf[r] = '0;
    repeat (3) @(negedge clk);
    chk({rd_en, wr_en, done, undef} == 4'b0, "R11 in reset", 64'({rd_en, wr_en, done, undef}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk({rd_en, wr_en, done, undef} == 4'b0, "R11 after reset", 64'({rd_en, wr_en, done, undef}), 64'd0);
    for (int rm = 0; rm < 4; rm++) begin
      for (int k = 0; k < 24; k++) begin
        int sf, df;
        bit quad;
        quad = k[0];
        load_all(rm * 5000 + k * 64);
        if (quad) begin
          sf = k % 8; df = (k % 5 == 0) ? sf : (k * 3 + 1) % 8;
          run_valid(mk_quad(sf, df), 1, sf, df, 2'(rm));
        end else begin
          sf = k % 16; df = (k % 5 == 0) ? sf : (k * 7 + 3) % 16;
          run_valid(mk_pair(sf, df), 0, sf, df, 2'(rm));
        end
      end
    end
    run_bad(mk_pair(3, 5) | 32'h1);
    run_bad(mk_quad(2, 6) | 32'h40);
    run_bad(mk_pair(1, 2) & ~32'h20);
    run_bad(32'h00000000);
    run_bad(mk_quad(1, 1) | 32'h2);
    $display("  [TB] %0d tests run, %0d failed", tests + m_tests, fails + m_fails);
    $finish;
  end
endmodule